// File: doc/BRIEF.md
# NAND Status-Check Sense Unit

This block sits on the NAND side of a DMA-driven flash controller. It checks one status byte from one NAND device. A PIO word transfer hands it three values: the index of the device to test, an expected status value and a bit mask. The unit then raises a read request with the chip enable of that device. When the status byte arrives on a byte-valid handshake, the unit XORs the byte with the expected value and applies the mask. It stores whether any masked bit differed in a sense flip-flop that belongs to that device alone.

The DMA engine reads the stored results through a sense line. It picks which device's flip-flop drives that line with the device index of the current channel. A true sense line tells the engine to follow its alternate command list. A false one lets it continue on the normal list. A one-cycle done pulse marks the end of the check, and the PIO-only command that started the check waits for that pulse before it completes.

Top module: `nand_sense_unit`

## Requirements
- R1: After reset, every per-device sense flip-flop holds 0, `pioReady` is 1, and both `statReq` and `checkDone` are 0.
- R2: When `pioValid` is high while `pioReady` is high, the unit latches `pioDev`, `pioExpect` and `pioMask`. From the next cycle, `statReq` is 1, `pioReady` is 0, and `statCe` is one-hot with bit `pioDev` set.
- R3: A status byte is accepted on a clock edge where `statReq` and `statValid` are both high. The sense flip-flop of the latched device then takes the value `((statByte ^ expected) & mask) != 0`: 1 when any masked bit differs, 0 when all masked bits match.
- R4: With a mask of all zeros, the stored sense is 0 whatever the status byte and the expected value are.
- R5: An accepted status byte changes only the flip-flop of the latched device. The flip-flops of the other devices keep their values.
- R6: `checkDone` is high for exactly the one cycle that follows the acceptance edge. `pioReady` is high again in the cycle after that, and `statReq` is low from the acceptance edge on.
- R7: `statValid` has no effect when `statReq` is low. It changes no sense flip-flop and produces no `checkDone`.
- R8: `pioValid` has no effect while a check is in progress. The expected value, the mask and the device latched at the start are the ones used.
- R9: `senseOut` shows the flip-flop selected by `chanDev` in the same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pioValid | input | 1 | Start request carrying the PIO-supplied check values |
| pioDev | input | DEV_W | Index of the device to check |
| pioExpect | input | STAT_W | Expected status value |
| pioMask | input | STAT_W | Bits of the status byte that take part in the compare |
| pioReady | output | 1 | Unit is idle and will take a start request |
| statReq | output | 1 | Status byte read is outstanding |
| statCe | output | NUM_DEV | One-hot chip enable of the device being read |
| statValid | input | 1 | Status byte present on `statByte` |
| statByte | input | STAT_W | Status byte read from the device |
| checkDone | output | 1 | One-cycle pulse that ends a check |
| chanDev | input | DEV_W | Device index of the current DMA channel |
| senseOut | output | 1 | Sense flip-flop of device `chanDev` |

## Verification
Showing that a check leaves the other devices alone is the hardest thing to observe from the ports. The sense line shows only one flip-flop at a time, and a flip-flop that is wrongly written with the same value it already holds looks unchanged. The bench first drives the devices into a mix of 1 and 0 results. It then sweeps `chanDev` across every device after each check and compares all of them with its own model. Between checks it also drives spurious `statValid` pulses and start requests that arrive while a check is busy, and it confirms that neither one disturbs the stored results.

// File: rtl/nsense_pkg.sv
package nsense_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // latch PIO-supplied device, expected value, mask
    logic accept;    // status byte taken this cycle
  } nsStrobe_t;

  typedef enum logic [1:0] {
    NS_IDLE = 2'd0,
    NS_READ = 2'd1,
    NS_DONE = 2'd2
  } nsState_t;

endpackage

// File: rtl/nsense_ctrl.sv
module nsense_ctrl
  import nsense_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pioValid,
  input  logic       statValid,
  output logic       pioReady,
  output logic       statReq,
  output logic       checkDone,
  output nsStrobe_t  strobe
);

  nsState_t stateQ, stateD;

  always_comb begin
    pioReady       = (stateQ == NS_IDLE);
    statReq        = (stateQ == NS_READ);
    checkDone      = (stateQ == NS_DONE);
    strobe.capture = pioReady && pioValid;
    strobe.accept  = statReq && statValid;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      NS_IDLE: if (strobe.capture) stateD = NS_READ;
      NS_READ: if (strobe.accept)  stateD = NS_DONE;
      NS_DONE: stateD = NS_IDLE;
      default: stateD = NS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= NS_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/nsense_dpath.sv
module nsense_dpath
  import nsense_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int STAT_W  = 8,
  parameter int DEV_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  nsStrobe_t           strobe,
  input  logic                statReq,
  input  logic [DEV_W-1:0]    pioDev,
  input  logic [STAT_W-1:0]   pioExpect,
  input  logic [STAT_W-1:0]   pioMask,
  input  logic [STAT_W-1:0]   statByte,
  input  logic [DEV_W-1:0]    chanDev,
  output logic [NUM_DEV-1:0]  statCe,
  output logic                senseOut
);

  logic [DEV_W-1:0]   devQ;
  logic [STAT_W-1:0]  expectQ;
  logic [STAT_W-1:0]  maskQ;
  logic [NUM_DEV-1:0] senseQ;
  logic               mismatch;

  // Check values held for the whole check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devQ    <= '0;
      expectQ <= '0;
      maskQ   <= '0;
    end else if (strobe.capture) begin
      devQ    <= pioDev;
      expectQ <= pioExpect;
      maskQ   <= pioMask;
    end
  end

  assign mismatch = |((statByte ^ expectQ) & maskQ);

  // One sense flip-flop and one chip enable per device
  for (genvar g = 0; g < NUM_DEV; g++) begin : gDev
    logic hit;
    assign hit       = (devQ == DEV_W'(g));
    assign statCe[g] = statReq && hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     senseQ[g] <= 1'b0;
      else if (strobe.accept && hit) senseQ[g] <= mismatch;
    end
  end

  always_comb begin
    senseOut = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (chanDev == DEV_W'(i)) senseOut = senseQ[i];
  end

endmodule

// File: rtl/nand_sense_unit.sv
module nand_sense_unit
  import nsense_pkg::*;
#(
  parameter  int NUM_DEV = 4,
  parameter  int STAT_W  = 8,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pioValid,
  input  logic [DEV_W-1:0]    pioDev,
  input  logic [STAT_W-1:0]   pioExpect,
  input  logic [STAT_W-1:0]   pioMask,
  output logic                pioReady,
  output logic                statReq,
  output logic [NUM_DEV-1:0]  statCe,
  input  logic                statValid,
  input  logic [STAT_W-1:0]   statByte,
  output logic                checkDone,
  input  logic [DEV_W-1:0]    chanDev,
  output logic                senseOut
);

  nsStrobe_t strobe;

  nsense_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pioValid  (pioValid),
    .statValid (statValid),
    .pioReady  (pioReady),
    .statReq   (statReq),
    .checkDone (checkDone),
    .strobe    (strobe)
  );

  nsense_dpath #(
    .NUM_DEV (NUM_DEV),
    .STAT_W  (STAT_W),
    .DEV_W   (DEV_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .statReq   (statReq),
    .pioDev    (pioDev),
    .pioExpect (pioExpect),
    .pioMask   (pioMask),
    .statByte  (statByte),
    .chanDev   (chanDev),
    .statCe    (statCe),
    .senseOut  (senseOut)
  );

endmodule

// File: rtl/nsense_chk.sv
module nsense_chk #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               pioReady,
  input logic               statReq,
  input logic [NUM_DEV-1:0] statCe,
  input logic               statValid,
  input logic               checkDone,
  input logic [DEV_W-1:0]   chanDev,
  input logic               senseOut
);

  AST_READY_XOR_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(pioReady && statReq)); // R2

  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    statReq |-> ($countones(statCe) == 1)); // R2

  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !statReq |-> (statCe == '0)); // R2

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (statReq && statValid) |=> (checkDone && !statReq)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |=> (!checkDone && pioReady)); // R6

  AST_SENSE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(statReq && statValid) |=> ($stable(senseOut) || !$stable(chanDev))); // R7

endmodule

bind nand_sense_unit nsense_chk #(
  .NUM_DEV (NUM_DEV),
  .DEV_W   (DEV_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pioReady  (pioReady),
  .statReq   (statReq),
  .statCe    (statCe),
  .statValid (statValid),
  .checkDone (checkDone),
  .chanDev   (chanDev),
  .senseOut  (senseOut)
);

// File: tb/sim_nand_sense_unit.sv
module sim_nand_sense_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV    = 4;
  localparam int STAT_W     = 8;
  localparam int DEV_W      = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pioValid = 1'b0;
  logic [DEV_W-1:0]  pioDev = '0;
  logic [STAT_W-1:0] pioExpect = '0;
  logic [STAT_W-1:0] pioMask = '0;
  logic              pioReady;
  logic              statReq;
  logic [NUM_DEV-1:0] statCe;
  logic              statValid = 1'b0;
  logic [STAT_W-1:0] statByte = '0;
  logic              checkDone;
  logic [DEV_W-1:0]  chanDev = '0;
  logic              senseOut;

  int nChecks = 0;
  int nFails  = 0;
  logic modelSense [NUM_DEV];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_sense_unit #(.NUM_DEV(NUM_DEV), .STAT_W(STAT_W)) u0 (
    .clk(clk), .rstN(rstN), .pioValid(pioValid), .pioDev(pioDev),
    .pioExpect(pioExpect), .pioMask(pioMask), .pioReady(pioReady),
    .statReq(statReq), .statCe(statCe), .statValid(statValid),
    .statByte(statByte), .checkDone(checkDone), .chanDev(chanDev),
    .senseOut(senseOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Compare every device flip-flop against the model through chanDev
  task automatic sweepSense(input string req);
    for (int d = 0; d < NUM_DEV; d++) begin
      chanDev = DEV_W'(d);
      #1;
      check(req, {31'b0, senseOut}, {31'b0, modelSense[d]});
    end
  endtask

  // One full check; strayPio drives a busy-time start request (R8)
  task automatic runCheck(input int dev, input logic [7:0] exp, input logic [7:0] msk,
                          input logic [7:0] sb, input int waitCyc, input bit strayPio);
    @(negedge clk);
    pioValid = 1'b1; pioDev = DEV_W'(dev); pioExpect = exp; pioMask = msk;
    @(negedge clk);
    pioValid = 1'b0;
    check("R2 statReq", {31'b0, statReq}, 32'd1);
    check("R2 pioReady", {31'b0, pioReady}, 32'd0);
    check("R2 statCe", {28'b0, statCe}, 32'd1 << dev);
    for (int i = 0; i < waitCyc; i++) begin
      if (strayPio) begin
        pioValid = 1'b1; pioDev = DEV_W'(dev + 1); pioExpect = ~exp; pioMask = 8'hFF;
      end
      @(negedge clk);
      pioValid = 1'b0;
      check("R8 still reading", {31'b0, statReq}, 32'd1);
    end
    statValid = 1'b1; statByte = sb;
    @(negedge clk);
    statValid = 1'b0;
    modelSense[dev] = (((sb ^ exp) & msk) != 8'h00);
    check("R6 done", {31'b0, checkDone}, 32'd1);
    check("R6 statReq low", {31'b0, statReq}, 32'd0);
    sweepSense("R3/R5 sense");
    @(negedge clk);
    check("R6 done single", {31'b0, checkDone}, 32'd0);
    check("R6 ready back", {31'b0, pioReady}, 32'd1);
  endtask

  task automatic testReset();
    check("R1 pioReady", {31'b0, pioReady}, 32'd1);
    check("R1 statReq", {31'b0, statReq}, 32'd0);
    check("R1 done", {31'b0, checkDone}, 32'd0);
    sweepSense("R1 sense clear");
  endtask

  task automatic testMatchMismatch();
    runCheck(0, 8'hA5, 8'hFF, 8'hA5, 0, 0);   // all match -> 0 (R3)
    runCheck(1, 8'hA5, 8'h0F, 8'hA4, 2, 0);   // low nibble differs -> 1 (R3)
    runCheck(2, 8'h40, 8'h40, 8'hBF, 1, 0);   // single masked bit differs -> 1
    runCheck(3, 8'h00, 8'hF0, 8'h0F, 0, 0);   // diff outside mask -> 0
  endtask

  task automatic testMaskZero();
    runCheck(1, 8'h00, 8'h00, 8'hFF, 0, 0);   // R4: clears device 1
    check("R4 mask zero", {31'b0, modelSense[1]}, 32'd0);
  endtask

  task automatic testIsolation();
    runCheck(3, 8'h81, 8'hFF, 8'h01, 0, 0);   // R5 device 3 -> 1
    runCheck(0, 8'h81, 8'hFF, 8'h7E, 1, 0);   // device 0 -> 1, others kept
    runCheck(0, 8'h81, 8'hFF, 8'h81, 0, 0);   // device 0 -> 0, 3 stays 1
  endtask

  task automatic testStrayStatValid();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      statValid = 1'b1; statByte = 8'h55 + 8'(i);
    end
    @(negedge clk);
    statValid = 1'b0;
    check("R7 no done", {31'b0, checkDone}, 32'd0);
    check("R7 idle", {31'b0, pioReady}, 32'd1);
    sweepSense("R7 sense unchanged");
  endtask

  task automatic testBusyPio();
    // stray request would force mismatch on dev 3; original gives match on dev 2
    runCheck(2, 8'h3C, 8'hFF, 8'h3C, 3, 1);
    check("R8 first values used", {31'b0, modelSense[2]}, 32'd0);
  endtask

  task automatic testSelectNoDelay();
    @(negedge clk);
    for (int d = 0; d < NUM_DEV; d++) begin
      chanDev = DEV_W'(d);
      #1;
      check("R9 same-cycle select", {31'b0, senseOut}, {31'b0, modelSense[d]});
    end
  endtask

  initial begin
    for (int d = 0; d < NUM_DEV; d++) modelSense[d] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMatchMismatch();
    testMaskZero();
    testIsolation();
    testStrayStatValid();
    testBusyPio();
    testSelectNoDelay();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule